// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator

An 8-bit pulse accumulator, controlled and read through one 16-bit register word. The upper byte holds control and status. The lower byte holds the count.

The block has two modes. In edge mode it counts transitions of chosen polarity on an asynchronous input pin. In gated mode it accumulates a chosen clock source while the input pin is at its non-inhibiting level. There are four gated clock sources:
- a free-running divide-by-512 of the system clock;
- the tick that advances an external 16-bit timer;
- that timer's overflow pulse;
- the rising edge of an external clock pin.

A sticky flag records each wrap of the count from 0xFF to 0x00. Software clears it with a strobe.

Software writes the control byte and the count through separate strobes. The read word always shows the synchronized pin levels, the control fields and the live count.

Top module: `pulse_accum`

## Requirements
- R1: After reset, the read word is 0x0000 when both pins are low, and the overflow flag is 0.
- R2: Read word layout, from bit 15 down to bit 8:
  - bit 15: synchronized input-pin level, read only;
  - bit 14: enable;
  - bit 13: mode (0 = edge, 1 = gated);
  - bit 12: polarity;
  - bit 11: synchronized external-clock-pin level, read only;
  - bit 10: channel select;
  - bits 9..8: clock select.

  Bits 7..0 hold the count. A control write does not change bits 15 and 11.
- R3: While enable is 0, no pin activity or clock source changes the count.
- R4: In edge mode, polarity 0 counts each falling edge of the input pin, and polarity 1 counts each rising edge.
- R5: In gated mode, polarity 0 stops counting while the pin is low, and polarity 1 stops counting while the pin is high.
- R6: Clock select codes in gated mode:
  - 00: one count per 512 system clocks, from a prescaler that runs freely;
  - 01: one count per timer tick pulse;
  - 10: one count per timer overflow pulse;
  - 11: one count per rising edge of the external clock pin.

  The count never advances by more than 1 per system clock.
- R7: A wrap of the count from 0xFF to 0x00 sets the overflow flag, which stays set until the clear strobe. If a set and a clear fall in the same cycle, the set wins.
- R8: A count write in the same cycle as an increment loads the written value. That cycle causes no increment and sets no overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_ctl | input | 1 | Write strobe for the control byte (wdata[15:8]) |
| wr_cnt | input | 1 | Write strobe for the count (wdata[7:0]) |
| wdata | input | 16 | Write data word |
| rdata | output | 16 | Read word: status, control and count |
| acc_pin | input | 1 | Asynchronous accumulator input pin |
| ext_clk_pin | input | 1 | Asynchronous external clock pin |
| tmr_tick | input | 1 | Single-cycle timer advance pulse |
| tmr_ovf | input | 1 | Single-cycle timer overflow pulse |
| ovf_clr | input | 1 | Clears the overflow flag |
| ovf_flag | output | 1 | Sticky count wrap flag |

## Verification
The bench measures the divide-by-512 source over a window of exactly 2048 enabled cycles. An off-by-one prescaler would yield 3 or 5 instead of 4.

It swaps polarity in both modes. A design that inverted the edge or the inhibit level would count the wrong transitions, or count while inhibited.

It writes the count in the same cycle as a timer tick, including at 0xFF. A design that let the increment win would read one higher, or would raise a false overflow.

It also writes all ones to the control byte. A design whose read-only bits were writable would echo those ones instead of the pin levels.

// File: rtl/pa_pkg.sv
package pa_pkg;
  typedef enum logic [1:0] {
    SRC_PRESC = 2'b00,
    SRC_TICK  = 2'b01,
    SRC_TOVF  = 2'b10,
    SRC_EXT   = 2'b11
  } clk_src_e;

  typedef struct packed {
    logic     en;
    logic     gated;
    logic     pol;
    logic     ch_sel;
    clk_src_e src;
  } ctl_t;
endpackage

// File: rtl/pa_sync.sv
module pa_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~prev;
  assign fall  = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/pa_clk_sel.sv
module pa_clk_sel
  import pa_pkg::*;
#(
  parameter int PRESC_W = 9
) (
  input  logic     clk,
  input  logic     rst,
  input  clk_src_e src,
  input  logic     tmr_tick,
  input  logic     tmr_ovf,
  input  logic     ext_rise,
  output logic     pulse
);
  localparam logic [PRESC_W-1:0] PRESC_LAST = {PRESC_W{1'b1}};

  logic [PRESC_W-1:0] presc;
  logic               presc_pulse;

  always_ff @(posedge clk) begin
    if (rst) presc <= '0;
    else     presc <= presc + 1'b1;
  end

  assign presc_pulse = (presc == PRESC_LAST);

  always_comb begin
    unique case (src)
      SRC_PRESC: pulse = presc_pulse;
      SRC_TICK:  pulse = tmr_tick;
      SRC_TOVF:  pulse = tmr_ovf;
      default:   pulse = ext_rise;
    endcase
  end

  assert_presc_spacing_R6: assert property (@(posedge clk) disable iff (rst)
    presc_pulse |=> !presc_pulse);
endmodule

// File: rtl/pa_counter.sv
module pa_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         wr,
  input  logic [W-1:0] wval,
  input  logic         ovf_clr,
  output logic [W-1:0] count,
  output logic         ovf_flag
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

  logic wrap;
  assign wrap = inc & ~wr & (count == ALL_ONES);

  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (wr)  count <= wval;
    else if (inc) count <= count + ONE;
  end

  always_ff @(posedge clk) begin
    if (rst)          ovf_flag <= 1'b0;
    else if (wrap)    ovf_flag <= 1'b1;
    else if (ovf_clr) ovf_flag <= 1'b0;
  end

  assert_wr_prio_R8: assert property (@(posedge clk) disable iff (rst)
    wr |=> count == $past(wval));
  assert_step_one_R6: assert property (@(posedge clk) disable iff (rst)
    !wr |=> (count == $past(count)) || (count == $past(count) + ONE));
  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (!wr && !inc) |=> $stable(count));
  assert_ovf_set_R7: assert property (@(posedge clk) disable iff (rst)
    (inc && !wr && count == ALL_ONES) |=> ovf_flag && count == '0);
endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
  import pa_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int PRESC_W = 9,
  parameter int SYNC_N  = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_ctl,
  input  logic        wr_cnt,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic        acc_pin,
  input  logic        ext_clk_pin,
  input  logic        tmr_tick,
  input  logic        tmr_ovf,
  input  logic        ovf_clr,
  output logic        ovf_flag
);
  ctl_t             ctl;
  logic             pin_lvl, pin_rise, pin_fall;
  logic             ext_lvl, ext_rise, ext_fall;
  logic             src_pulse, edge_hit, gate_open, inc;
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl <= '{en: 1'b0, gated: 1'b0, pol: 1'b0, ch_sel: 1'b0, src: SRC_PRESC};
    end else if (wr_ctl) begin
      ctl.en     <= wdata[14];
      ctl.gated  <= wdata[13];
      ctl.pol    <= wdata[12];
      ctl.ch_sel <= wdata[10];
      ctl.src    <= clk_src_e'(wdata[9:8]);
    end
  end

  pa_sync #(.STAGES(SYNC_N)) u_pin_sync (
    .clk(clk), .rst(rst), .din(acc_pin),
    .level(pin_lvl), .rise(pin_rise), .fall(pin_fall)
  );

  pa_sync #(.STAGES(SYNC_N)) u_ext_sync (
    .clk(clk), .rst(rst), .din(ext_clk_pin),
    .level(ext_lvl), .rise(ext_rise), .fall(ext_fall)
  );

  pa_clk_sel #(.PRESC_W(PRESC_W)) u_clk_sel (
    .clk(clk), .rst(rst), .src(ctl.src), .tmr_tick(tmr_tick),
    .tmr_ovf(tmr_ovf), .ext_rise(ext_rise), .pulse(src_pulse)
  );

  assign edge_hit  = ctl.pol ? pin_rise : pin_fall;
  assign gate_open = (pin_lvl != ctl.pol);
  assign inc       = ctl.en & (ctl.gated ? (src_pulse & gate_open) : edge_hit);

  pa_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .inc(inc), .wr(wr_cnt), .wval(wdata[CNT_W-1:0]),
    .ovf_clr(ovf_clr), .count(count), .ovf_flag(ovf_flag)
  );

  always_comb begin
    rdata       = '0;
    rdata[15]   = pin_lvl;
    rdata[14]   = ctl.en;
    rdata[13]   = ctl.gated;
    rdata[12]   = ctl.pol;
    rdata[11]   = ext_lvl;
    rdata[10]   = ctl.ch_sel;
    rdata[9:8]  = ctl.src;
    rdata[CNT_W-1:0] = count;
  end

  assert_idle_disabled_R3: assert property (@(posedge clk) disable iff (rst)
    (!ctl.en && !wr_cnt) |=> $stable(count));
  assert_edge_mode_R4: assert property (@(posedge clk) disable iff (rst)
    (ctl.en && !ctl.gated && !wr_cnt && !pin_rise && !pin_fall) |=> $stable(count));
  assert_gate_inhibit_R5: assert property (@(posedge clk) disable iff (rst)
    (ctl.en && ctl.gated && !wr_cnt && pin_lvl == ctl.pol) |=> $stable(count));
endmodule

// File: tb/tb_pulse_accum.sv
module tb_pulse_accum;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_ctl = 1'b0, wr_cnt = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        acc_pin = 1'b0, ext_clk_pin = 1'b0;
  logic        tmr_tick = 1'b0, tmr_ovf = 1'b0, ovf_clr = 1'b0;
  logic        ovf_flag;
  int          total = 0, bad = 0;

  always #2.5 clk = ~clk;

  pulse_accum dut (
    .clk(clk), .rst(rst), .wr_ctl(wr_ctl), .wr_cnt(wr_cnt), .wdata(wdata),
    .rdata(rdata), .acc_pin(acc_pin), .ext_clk_pin(ext_clk_pin),
    .tmr_tick(tmr_tick), .tmr_ovf(tmr_ovf), .ovf_clr(ovf_clr), .ovf_flag(ovf_flag)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge, returns at the next negedge
  task automatic put_ctl(input logic [7:0] c);
    wr_ctl = 1'b1; wdata = {c, 8'h00};
    @(negedge clk); wr_ctl = 1'b0;
  endtask

  task automatic put_cnt(input logic [7:0] v);
    wr_cnt = 1'b1; wdata = {8'h00, v};
    @(negedge clk); wr_cnt = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic pin_to(input logic v);
    acc_pin = v; settle();
  endtask

  task automatic pulse_tick(input int n);
    for (int i = 0; i < n; i++) begin
      tmr_tick = 1'b1; @(negedge clk); tmr_tick = 1'b0; @(negedge clk);
    end
    settle();
  endtask

  // control byte: {pin, en, gated, pol, ext, ch, src[1:0]}
  task automatic t_reset();
    check("R1 read word", rdata, 16'h0000);
    check("R1 flag", {15'd0, ovf_flag}, 16'd0);
  endtask

  task automatic t_layout();
    acc_pin = 1'b1; ext_clk_pin = 1'b0; settle();
    put_ctl(8'hFF); settle();
    check("R2 ro bits follow pins", {8'h00, rdata[15:8]}, 16'h00F7);
    put_ctl(8'h00); acc_pin = 1'b0; settle();
    check("R2 cleared ctl", rdata, 16'h0000);
  endtask

  task automatic t_disabled();
    put_ctl(8'h21); // gated, tick, not enabled
    acc_pin = 1'b1; settle(); pulse_tick(3);
    pin_to(1'b0); pin_to(1'b1); pin_to(1'b0);
    check("R3 no count when disabled", {8'h00, rdata[7:0]}, 16'h0000);
  endtask

  task automatic t_edges();
    put_cnt(8'h00);
    put_ctl(8'h40); // edge, falling
    for (int i = 0; i < 3; i++) begin pin_to(1'b1); pin_to(1'b0); end
    check("R4 falling edges", {8'h00, rdata[7:0]}, 16'h0003);
    pin_to(1'b1);
    check("R4 rising ignored with pol0", {8'h00, rdata[7:0]}, 16'h0003);
    put_ctl(8'h50); // edge, rising
    pin_to(1'b0); pin_to(1'b1); pin_to(1'b0); pin_to(1'b1);
    check("R4 rising edges", {8'h00, rdata[7:0]}, 16'h0005);
    put_ctl(8'h00); pin_to(1'b0);
  endtask

  task automatic t_gate();
    put_cnt(8'h00);
    put_ctl(8'h61); // en gated pol0 tick
    pin_to(1'b0); pulse_tick(4);
    check("R5 pol0 inhibited low", {8'h00, rdata[7:0]}, 16'h0000);
    pin_to(1'b1); pulse_tick(4);
    check("R5 pol0 counts high", {8'h00, rdata[7:0]}, 16'h0004);
    put_ctl(8'h71); // pol1
    pulse_tick(2);
    check("R5 pol1 inhibited high", {8'h00, rdata[7:0]}, 16'h0004);
    pin_to(1'b0); pulse_tick(2);
    check("R5 pol1 counts low", {8'h00, rdata[7:0]}, 16'h0006);
    put_ctl(8'h00);
  endtask

  task automatic t_sources();
    put_cnt(8'h00); pin_to(1'b1);
    put_ctl(8'h60); // presc
    repeat (2047) @(negedge clk);
    put_ctl(8'h00);
    check("R6 presc 2048 cycles", {8'h00, rdata[7:0]}, 16'h0004);
    put_cnt(8'h00);
    put_ctl(8'h62); // timer overflow
    pulse_tick(3);
    for (int i = 0; i < 5; i++) begin
      tmr_ovf = 1'b1; @(negedge clk); tmr_ovf = 1'b0; @(negedge clk);
    end
    settle();
    check("R6 timer overflow source", {8'h00, rdata[7:0]}, 16'h0005);
    put_cnt(8'h00);
    put_ctl(8'h63); // ext pin
    for (int i = 0; i < 6; i++) begin
      ext_clk_pin = 1'b1; repeat (4) @(negedge clk);
      ext_clk_pin = 1'b0; repeat (4) @(negedge clk);
    end
    settle();
    check("R6 ext clock source", {8'h00, rdata[7:0]}, 16'h0006);
    put_ctl(8'h00);
  endtask

  task automatic t_overflow();
    put_cnt(8'hFE); pin_to(1'b1);
    put_ctl(8'h61);
    pulse_tick(2);
    check("R7 wrap count", {8'h00, rdata[7:0]}, 16'h0000);
    check("R7 flag set", {15'd0, ovf_flag}, 16'd1);
    pulse_tick(1);
    check("R7 flag sticky", {15'd0, ovf_flag}, 16'd1);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0; @(negedge clk);
    check("R7 flag cleared", {15'd0, ovf_flag}, 16'd0);
    put_cnt(8'hFF);
    ovf_clr = 1'b1; tmr_tick = 1'b1; @(negedge clk);
    ovf_clr = 1'b0; tmr_tick = 1'b0; @(negedge clk);
    check("R7 set beats clear", {15'd0, ovf_flag}, 16'd1);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0; @(negedge clk);
  endtask

  task automatic t_priority();
    put_cnt(8'h10);
    tmr_tick = 1'b1; wr_cnt = 1'b1; wdata = 16'h0055; @(negedge clk);
    tmr_tick = 1'b0; wr_cnt = 1'b0; @(negedge clk);
    check("R8 write beats tick", {8'h00, rdata[7:0]}, 16'h0055);
    pulse_tick(1);
    check("R8 tick after write", {8'h00, rdata[7:0]}, 16'h0056);
    put_cnt(8'hFF);
    tmr_tick = 1'b1; wr_cnt = 1'b1; wdata = 16'h00FF; @(negedge clk);
    tmr_tick = 1'b0; wr_cnt = 1'b0; @(negedge clk);
    check("R8 no wrap on write", {7'd0, ovf_flag, rdata[7:0]}, 16'h00FF);
    put_ctl(8'h00);
  endtask

  initial begin
    fork
      begin : wd
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=expired expected=done");
      end
      begin
        repeat (4) @(negedge clk);
        rst = 1'b0; @(negedge clk);
        t_reset(); t_layout(); t_disabled(); t_edges();
        t_gate(); t_sources(); t_overflow(); t_priority();
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule